// File: doc/BRIEF.md
# Self-Restoring Cellular Automaton Array

This block is a two-dimensional grid of identical cells (4 rows by 4 columns by default). Each cell holds a small multi-valued state. On every step each cell replaces its state with an entry from a constant rule table. The entry is selected by two neighbour values only: the state of the cell directly above it (north) and the state of the cell directly to its left (west). The cell's own present value is not used. The top row reads its north value, and the left column reads its west value, from fixed boundary constants that never change. Signals therefore travel one way, towards the bottom-right corner. Whatever the array starts from, it settles into one steady pattern within a bounded number of steps. After an upset it rebuilds that pattern without any explicit error detection.

A second constant table maps each cell state onto one pattern bit. That bit selects the configuration of the matching cell in a separate functional logic layer. Because cell states can be wider than one bit, a single configuration bit can be reached through more than one state, which keeps the rule table free of conflicts.

For fault emulation, every cell has a one-cycle write port and a stuck-at mode, and the block reports two flags. A sticky flag records that a neighbour pair was missing from the rule table. A converged flag reports that a step left the state vector unchanged. The rule table, the boundaries and the map are parameters. The rule set itself is computed elsewhere.

Top module: `cca_array`

## Requirements
- R1: While rst_n is low at a rising clock edge, every cell state becomes 0, miss_flag becomes 0 and converged becomes 0.
- R2: On a rising edge with step_en high, every cell whose inject and stuck inputs are both low loads the rule output for its (north, west) pair. All cells take their neighbour values from before that edge. Cell k = r*COLS + c occupies state_vec[k*SW +: SW]. North is cell k-COLS, or TOP_BOUND[c*SW +: SW] for row 0. West is cell k-1, or LEFT_BOUND[r*SW +: SW] for column 0.
- R3: On an edge with step_en low and no inject or stuck input set, state_vec keeps its value.
- R4: pattern_vec[k] equals bit s of STATE_MAP, where s is the present state of cell k. This path is combinational.
- R5: When a stepped cell's (north, west) pair matches no rule entry, that cell loads 0 and miss_flag is set. miss_flag then stays at 1 until reset.
- R6: From any contents, ROWS+COLS-1 steps with no inject or stuck input bring the array to its steady pattern. With the default tables, the steady state of cell (r, c) is r+c+1.
- R7: inj_en[k] high at an edge loads force_val[k*SW +: SW] into cell k, whether or not step_en is high. On later steps the cell follows the rules again.
- R8: While stuck_en[k] is high, cell k loads force_val[k*SW +: SW] at every edge, and its neighbours see that value. Stuck takes priority over stepping.
- R9: On every edge where step_en or any inject or stuck bit is high, converged becomes 1 exactly when step_en is high and no cell changes value. On all other edges it holds.
- R10: After one cell is corrupted, the steady pattern returns within ROWS+COLS-1 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance all cells by one rule iteration |
| inj_en | input | ROWS*COLS | One-cycle write of force_val into each selected cell |
| stuck_en | input | ROWS*COLS | Hold each selected cell at its force_val |
| force_val | input | ROWS*COLS*SW | Value per cell used by inject and stuck |
| state_vec | output | ROWS*COLS*SW | All cell states, cell k at bits k*SW upward |
| pattern_vec | output | ROWS*COLS | Mapped configuration bit per cell |
| miss_flag | output | 1 | Sticky rule-table miss indicator |
| converged | output | 1 | Last step changed no cell |

## Verification
The hardest condition to reach from the ports is a stepped cell whose neighbour pair is missing from the table while the rest of the array is still legal. Seeding all cells from reset reaches it: the second step presents (1,1) to the interior cells. Injecting a stray value in a corner reaches it as well, because the downstream cells then see pairs such as (0,5). A stuck cell held for several steps keeps the downstream region in a state that differs from the steady pattern. Releasing the cell then shows whether the array recovers within the stated step bound. A behavioural model tracks every cycle of these sequences.

// File: rtl/cca_pkg.sv
// Package: shared helpers for the self-restoring cellular array.
// Assumes cells are numbered row-major, index = row*COLS + col.
package cca_pkg;

    // Row-major cell index for (row, col) in a grid with cols columns.
    function automatic int cell_index(input int row, input int col, input int cols);
        return row * cols + col;
    endfunction

endpackage

// File: rtl/cca_rule_lut.sv
// Rule lookup: returns the output field of the rule whose (north, west)
// key matches the inputs, and a hit flag. Assumes keys are unique; if
// duplicated, the lowest entry wins. A miss returns 0.
module cca_rule_lut #(
    parameter int SW     = 3,
    parameter int NRULES = 12,
    parameter logic [NRULES*SW-1:0] RULE_N = '0,
    parameter logic [NRULES*SW-1:0] RULE_W = '0,
    parameter logic [NRULES*SW-1:0] RULE_O = '0
) (
    input  logic [SW-1:0] north,
    input  logic [SW-1:0] west,
    output logic [SW-1:0] rule_out,
    output logic          hit
);
    logic [NRULES-1:0] match;

    // One comparator per rule entry.
    for (genvar i = 0; i < NRULES; i++) begin : g_match
        assign match[i] = (RULE_N[i*SW +: SW] == north) && (RULE_W[i*SW +: SW] == west);
    end

    // Select the first matching entry, default 0 on a miss.
    always_comb begin
        rule_out = '0;
        hit      = 1'b0;
        for (int i = NRULES - 1; i >= 0; i--) begin
            if (match[i]) begin
                rule_out = RULE_O[i*SW +: SW];
                hit      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cca_cell.sv
// One automaton cell: a state register updated from the rule lookup of
// its north and west inputs, with fault-emulation overrides (stuck has
// priority, then inject, then step). Its own state is not a rule input.
module cca_cell #(
    parameter int SW     = 3,
    parameter int NRULES = 12,
    parameter logic [NRULES*SW-1:0] RULE_N = '0,
    parameter logic [NRULES*SW-1:0] RULE_W = '0,
    parameter logic [NRULES*SW-1:0] RULE_O = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          inj,
    input  logic          stuck,
    input  logic [SW-1:0] fval,
    input  logic [SW-1:0] north,
    input  logic [SW-1:0] west,
    output logic [SW-1:0] state,
    output logic          miss,
    output logic          changed
);
    logic [SW-1:0] rule_out;
    logic          hit;
    logic          forced;
    logic          upd;
    logic [SW-1:0] nxt;

    cca_rule_lut #(
        .SW(SW), .NRULES(NRULES),
        .RULE_N(RULE_N), .RULE_W(RULE_W), .RULE_O(RULE_O)
    ) lut_i (
        .north(north), .west(west), .rule_out(rule_out), .hit(hit)
    );

    // Choose the next value and report a miss or a change.
    always_comb begin
        forced  = stuck | inj;
        upd     = forced | step;
        nxt     = forced ? fval : rule_out;
        miss    = step & ~forced & ~hit;
        changed = upd & (nxt != state);
    end

    // State register with synchronous reset to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
        end else if (upd) begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/cca_state_map.sv
// State map: turns each cell state into its configuration bit by
// indexing a constant table of 2**SW bits. Purely combinational.
module cca_state_map #(
    parameter int NCELLS = 16,
    parameter int SW     = 3,
    parameter logic [(1<<SW)-1:0] STATE_MAP = '0
) (
    input  logic [NCELLS*SW-1:0] states,
    output logic [NCELLS-1:0]    pattern
);
    // One table read per cell.
    for (genvar k = 0; k < NCELLS; k++) begin : g_map
        assign pattern[k] = STATE_MAP[states[k*SW +: SW]];
    end
endmodule

// File: rtl/cca_array.sv
// Top: ROWS x COLS grid of cells with one-way north/west coupling,
// fixed top and left boundaries, a state-to-pattern map, a sticky miss
// flag and a converged flag. All cells update on the same edge.
module cca_array #(
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int SW     = 3,
    parameter int NRULES = 12,
    parameter logic [NRULES*SW-1:0] RULE_N = {3'd6,3'd5,3'd4,3'd3,3'd2,3'd3,3'd2,3'd1,3'd0,3'd0,3'd0,3'd0},
    parameter logic [NRULES*SW-1:0] RULE_W = {3'd6,3'd5,3'd4,3'd3,3'd2,3'd0,3'd0,3'd0,3'd3,3'd2,3'd1,3'd0},
    parameter logic [NRULES*SW-1:0] RULE_O = {3'd7,3'd6,3'd5,3'd4,3'd3,3'd4,3'd3,3'd2,3'd4,3'd3,3'd2,3'd1},
    parameter logic [COLS*SW-1:0]   TOP_BOUND  = '0,
    parameter logic [ROWS*SW-1:0]   LEFT_BOUND = '0,
    parameter logic [(1<<SW)-1:0]   STATE_MAP  = 8'hA5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_en,
    input  logic [ROWS*COLS-1:0]      inj_en,
    input  logic [ROWS*COLS-1:0]      stuck_en,
    input  logic [ROWS*COLS*SW-1:0]   force_val,
    output logic [ROWS*COLS*SW-1:0]   state_vec,
    output logic [ROWS*COLS-1:0]      pattern_vec,
    output logic                      miss_flag,
    output logic                      converged
);
    import cca_pkg::*;

    localparam int NCELLS = ROWS * COLS;

    logic [SW-1:0]     cur [NCELLS];
    logic [NCELLS-1:0] miss_v;
    logic [NCELLS-1:0] chg_v;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int K = cell_index(r, c, COLS);
            logic [SW-1:0] n_in;
            logic [SW-1:0] w_in;

            if (r == 0) begin : g_ntop
                assign n_in = TOP_BOUND[c*SW +: SW];
            end else begin : g_nin
                assign n_in = cur[K-COLS];
            end

            if (c == 0) begin : g_wleft
                assign w_in = LEFT_BOUND[r*SW +: SW];
            end else begin : g_win
                assign w_in = cur[K-1];
            end

            cca_cell #(
                .SW(SW), .NRULES(NRULES),
                .RULE_N(RULE_N), .RULE_W(RULE_W), .RULE_O(RULE_O)
            ) cell_i (
                .clk(clk), .rst_n(rst_n), .step(step_en),
                .inj(inj_en[K]), .stuck(stuck_en[K]),
                .fval(force_val[K*SW +: SW]),
                .north(n_in), .west(w_in),
                .state(cur[K]), .miss(miss_v[K]), .changed(chg_v[K])
            );

            assign state_vec[K*SW +: SW] = cur[K];
        end
    end

    cca_state_map #(
        .NCELLS(NCELLS), .SW(SW), .STATE_MAP(STATE_MAP)
    ) map_i (
        .states(state_vec), .pattern(pattern_vec)
    );

    // Sticky record of any rule-table miss on a stepped cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_flag <= 1'b0;
        end else if (|miss_v) begin
            miss_flag <= 1'b1;
        end
    end

    // Converged: last update was a step that changed no cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            converged <= 1'b0;
        end else if (step_en || (|inj_en) || (|stuck_en)) begin
            converged <= step_en && !(|chg_v);
        end
    end
endmodule

// File: rtl/cca_array_chk.sv
// Checker for cca_array: temporal properties on its ports, bound below.
module cca_array_chk #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int SW   = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    step_en,
    input logic [ROWS*COLS-1:0]    inj_en,
    input logic [ROWS*COLS-1:0]    stuck_en,
    input logic [ROWS*COLS*SW-1:0] force_val,
    input logic [ROWS*COLS*SW-1:0] state_vec,
    input logic [ROWS*COLS-1:0]    pattern_vec,
    input logic                    miss_flag,
    input logic                    converged
);
    localparam int NCELLS = ROWS * COLS;

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (state_vec == '0) && !miss_flag && !converged);

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && inj_en == '0 && stuck_en == '0) |=> $stable(state_vec));

    a_r5_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        miss_flag |=> miss_flag);

    a_r9_conv_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(converged) |-> $past(step_en));

    for (genvar k = 0; k < NCELLS; k++) begin : g_cell
        a_r8_stuck_hold: assert property (@(posedge clk) disable iff (!rst_n)
            stuck_en[k] |=> state_vec[k*SW +: SW] == $past(force_val[k*SW +: SW]));

        a_r7_inject_load: assert property (@(posedge clk) disable iff (!rst_n)
            (inj_en[k] && !stuck_en[k]) |=> state_vec[k*SW +: SW] == $past(force_val[k*SW +: SW]));
    end
endmodule

bind cca_array cca_array_chk #(.ROWS(ROWS), .COLS(COLS), .SW(SW)) chk_i (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .inj_en(inj_en),
    .stuck_en(stuck_en), .force_val(force_val), .state_vec(state_vec),
    .pattern_vec(pattern_vec), .miss_flag(miss_flag), .converged(converged)
);

// File: tb/cca_array_tb_top.sv
// Bench: behavioural per-cycle model of the array, compared every clock,
// plus directed checks of reset, convergence, upsets and stuck cells.
module cca_array_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int R = 4;
    localparam int C = 4;
    localparam int N = 16;
    localparam int SW = 3;
    localparam int NR = 12;
    localparam int BOUND = R + C - 1;
    localparam logic [7:0] MAP = 8'hA5;

    int rn[NR] = '{0,0,0,0,1,2,3,2,3,4,5,6};
    int rw[NR] = '{0,1,2,3,0,0,0,2,3,4,5,6};
    int ro[NR] = '{1,2,3,4,2,3,4,3,4,5,6,7};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_en = 1'b0;
    logic [N-1:0] inj_en = '0;
    logic [N-1:0] stuck_en = '0;
    logic [N*SW-1:0] force_val = '0;
    logic [N*SW-1:0] state_vec;
    logic [N-1:0] pattern_vec;
    logic miss_flag;
    logic converged;

    int checks = 0;
    int errors = 0;
    int m_st[N];
    int m_miss = 0;
    int m_conv = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    cca_array dut_i (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .inj_en(inj_en),
        .stuck_en(stuck_en), .force_val(force_val), .state_vec(state_vec),
        .pattern_vec(pattern_vec), .miss_flag(miss_flag), .converged(converged)
    );

    function automatic int steady(input int k);
        return (k / C) + (k % C) + 1;
    endfunction

    function automatic int fv(input int k);
        return int'(force_val[k*SW +: SW]);
    endfunction

    task automatic check(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // Compare every output against the model.
    task automatic compare_all();
        for (int k = 0; k < N; k++) begin
            check(tag, $sformatf("state[%0d]", k), int'(state_vec[k*SW +: SW]), m_st[k]);
            check("R4", $sformatf("pattern[%0d]", k), int'(pattern_vec[k]), int'(MAP[m_st[k]]));
        end
        check("R5", "miss_flag", int'(miss_flag), m_miss);
        check("R9", "converged", int'(converged), m_conv);
    endtask

    // One clock: advance the model from current inputs, then compare.
    task automatic tick();
        int nx[N];
        int any_force;
        int chg;
        any_force = (inj_en != 0) || (stuck_en != 0);
        chg = 0;
        if (!rst_n) begin
            for (int k = 0; k < N; k++) nx[k] = 0;
            m_miss = 0;
            m_conv = 0;
        end else begin
            for (int k = 0; k < N; k++) begin
                int n = (k / C == 0) ? 0 : m_st[k-C];
                int w = (k % C == 0) ? 0 : m_st[k-1];
                int o = -1;
                nx[k] = m_st[k];
                if (stuck_en[k] || inj_en[k]) nx[k] = fv(k);
                else if (step_en) begin
                    for (int i = 0; i < NR; i++)
                        if (o < 0 && rn[i] == n && rw[i] == w) o = ro[i];
                    if (o < 0) begin
                        o = 0;
                        m_miss = 1;
                    end
                    nx[k] = o;
                end
                if (nx[k] != m_st[k]) chg = 1;
            end
            if (step_en || any_force) m_conv = (step_en && !chg) ? 1 : 0;
        end
        @(posedge clk);
        for (int k = 0; k < N; k++) m_st[k] = nx[k];
        @(negedge clk);
        compare_all();
    endtask

    function automatic int at_steady();
        for (int k = 0; k < N; k++)
            if (int'(state_vec[k*SW +: SW]) != steady(k)) return 0;
        return 1;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog R1..: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int steps;
        for (int k = 0; k < N; k++) m_st[k] = 0;
        @(negedge clk);
        tag = "R1";
        tick(); tick();
        check("R1", "reset miss", int'(miss_flag), 0);
        check("R1", "reset conv", int'(converged), 0);
        check("R1", "reset state", int'(state_vec == '0), 1);
        rst_n = 1'b1;

        // R2/R5: first step finds only known pairs, second hits a miss.
        tag = "R2";
        step_en = 1'b1;
        tick();
        check("R5", "no miss after step 1", int'(miss_flag), 0);
        check("R2", "cell5 after step 1", int'(state_vec[5*SW +: SW]), 1);
        tick();
        check("R5", "miss after step 2", int'(miss_flag), 1);
        for (int s = 2; s < BOUND; s++) tick();
        check("R6", "steady after bound from reset", at_steady(), 1);
        tick();
        check("R9", "converged after still step", int'(converged), 1);

        // R3: idle cycles keep the state.
        tag = "R3";
        step_en = 1'b0;
        repeat (3) tick();
        check("R3", "idle holds steady", at_steady(), 1);
        check("R5", "miss still sticky", int'(miss_flag), 1);

        // R7/R10: single upset in corner cell 0.
        tag = "R7";
        force_val[0*SW +: SW] = 3'd5;
        inj_en[0] = 1'b1;
        tick();
        inj_en = '0;
        check("R7", "inject cell0", int'(state_vec[0 +: SW]), 5);
        check("R9", "conv cleared by inject", int'(converged), 0);
        tag = "R10";
        step_en = 1'b1;
        steps = 0;
        while (!at_steady() && steps < 20) begin
            tick();
            steps++;
        end
        check("R10", "recovery within bound", int'(steps <= BOUND && steps > 0), 1);

        // R6: multi-cell upset with arbitrary values while stepping.
        tag = "R6";
        for (int k = 0; k < N; k++) force_val[k*SW +: SW] = 3'((k * 5 + 3) % 8);
        inj_en = 16'hB6D3;
        tick();
        inj_en = '0;
        for (int s = 0; s < BOUND; s++) tick();
        check("R6", "steady after multi upset", at_steady(), 1);

        // R8: stuck cell 5 at 2 while stepping, then release.
        tag = "R8";
        force_val[5*SW +: SW] = 3'd2;
        stuck_en[5] = 1'b1;
        repeat (8) tick();
        check("R8", "stuck cell holds", int'(state_vec[5*SW +: SW]), 2);
        check("R8", "downstream cell15 disturbed", int'(state_vec[15*SW +: SW] != 3'd7), 1);
        stuck_en = '0;
        for (int s = 0; s < BOUND; s++) tick();
        check("R8", "recovered after release", at_steady(), 1);

        // R1: reset mid-run clears everything.
        tag = "R1";
        step_en = 1'b0;
        rst_n = 1'b0;
        tick();
        check("R1", "mid-run reset miss", int'(miss_flag), 0);
        rst_n = 1'b1;
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule